// File: doc/BRIEF.md
# Min-Sum Polar Update Element

This block carries out both successive-cancellation update rules that a polar decoder needs at each node, on two signed log-likelihood ratios of `Q` bits each. It outputs the min-sum ("f") combination of the two inputs. It also outputs the sum `b + a` and the difference `b - a`. A partial-sum bit `u` chooses which of the two candidates becomes the "g" result. All four results are registered once, so every output reflects the operands sampled at the previous rising clock edge.

Addition and subtraction run in a single ripple structure. Each bit slice shares one XOR term between the sum bit and the difference bit, and keeps its carry and borrow on separate chains. The min-sum comparison uses no comparator of its own. A second instance of the same adder-subtractor runs on the operand magnitudes, and its final borrow decides which magnitude is smaller. The magnitudes come from a conversion to sign-magnitude form that is one bit wider than the input, so that the most negative input keeps its true magnitude. Every result is squeezed back to `Q` bits with saturation.

Top module: `polar_minsum_pe`

## Requirements
- R1: While `rst_n` is low, all four outputs read zero.
- R2: Each output is a registered function of the inputs present at the preceding rising edge of `clk`, and it does not change between edges.
- R3: `sum_o` equals `b + a`, clamped to the `Q`-bit two's-complement range [-2^(Q-1), 2^(Q-1)-1].
- R4: `diff_o` equals `b - a`, clamped to the same range.
- R5: `g_o` equals `sum_o` when `u` was 0, and equals `diff_o` when `u` was 1.
- R6: The sign of a nonzero `f_o` is the XOR of the two input sign bits (bit Q-1). `f_o` is zero whenever either input is zero.
- R7: The magnitude of `f_o` is the smaller of |a| and |b|, where the most negative input -2^(Q-1) has magnitude 2^(Q-1).
- R8: A positive min-sum result of magnitude 2^(Q-1) saturates to 2^(Q-1)-1. A negative result of that magnitude is given as -2^(Q-1).
- R9: When |a| equals |b|, `f_o` is the same whichever operand is taken as the minimum, so swapping `a` and `b` leaves `f_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| llr_a_i | input | Q | First LLR operand, two's complement |
| llr_b_i | input | Q | Second LLR operand, two's complement |
| u_i | input | 1 | Partial-sum bit that selects the g candidate |
| f_o | output | Q | Min-sum result |
| sum_o | output | Q | Saturated b + a |
| diff_o | output | Q | Saturated b - a |
| g_o | output | Q | Selected candidate (sum or difference) |

## Verification
The bench builds the element with `Q = 5`. That width is small enough to sweep every operand pair, for both values of `u`, against a reference computed from integer arithmetic. The sweep covers the signed overflow cases of the sum and the difference, and the most negative input meeting itself and every other value. It also covers both outcomes of the magnitude borrow, including equal magnitudes. Directed tasks add checks of the value held during reset, the one-edge timing, and operand swaps with equal magnitudes.

// File: rtl/polar_pe_pkg.sv
package polar_pe_pkg;
  // Meaning of the partial-sum select bit for the g result.
  typedef enum logic {
    SEL_SUM  = 1'b0,
    SEL_DIFF = 1'b1
  } g_sel_e;
endpackage

// File: rtl/pe_addsub_chain.sv
// Joint ripple adder-subtractor: sum = x + y, diff = x - y.
// The XOR term is shared per slice; carry and borrow ripple separately.
module pe_addsub_chain #(
  parameter int W = 6
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic         carry_o,
  output logic         borrow_o
);
  logic [W-1:0] cy;
  logic [W-1:0] bw;
  logic [W-1:0] xr;

  for (genvar i = 0; i < W; i++) begin : g_slice
    assign xr[i] = x_i[i] ^ y_i[i];
    if (i == 0) begin : g_half
      assign sum_o[i]  = xr[i];
      assign diff_o[i] = xr[i];
      assign cy[i]     = x_i[i] & y_i[i];
      assign bw[i]     = ~x_i[i] & y_i[i];
    end else begin : g_full
      assign sum_o[i]  = xr[i] ^ cy[i-1];
      assign diff_o[i] = xr[i] ^ bw[i-1];
      assign cy[i]     = (x_i[i] & y_i[i]) | (xr[i] & cy[i-1]);
      assign bw[i]     = (~x_i[i] & y_i[i]) | (~xr[i] & bw[i-1]);
    end
  end

  assign carry_o  = cy[W-1];
  assign borrow_o = bw[W-1];
endmodule

// File: rtl/pe_tc_to_sm.sv
// Two's complement to sign-magnitude. The result is one bit wider than the
// input ({sign, W-bit magnitude}), so that -2^(W-1) yields magnitude 2^(W-1).
module pe_tc_to_sm #(
  parameter int W = 5
) (
  input  logic [W-1:0] val_i,
  output logic         sign_o,
  output logic [W-1:0] mag_o
);
  logic [W-1:0] inv;
  logic [W-1:0] inc_cy;
  logic [W-1:0] neg;

  assign inv = ~val_i;

  // Increment of the inverted value through a half-adder ripple.
  for (genvar i = 0; i < W; i++) begin : g_inc
    if (i == 0) begin : g_lsb
      assign inc_cy[i] = 1'b1;
    end else begin : g_up
      assign inc_cy[i] = inv[i-1] & inc_cy[i-1];
    end
    assign neg[i] = inv[i] ^ inc_cy[i];
  end

  assign sign_o = val_i[W-1];
  assign mag_o  = sign_o ? neg : val_i;
endmodule

// File: rtl/pe_sat_narrow.sv
// Narrows a (W+1)-bit two's-complement value to W bits with clamping.
module pe_sat_narrow #(
  parameter int W = 5
) (
  input  logic [W:0]   wide_i,
  output logic [W-1:0] narrow_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic ovf;
  assign ovf = wide_i[W] ^ wide_i[W-1];

  always_comb begin
    if (!ovf)           narrow_o = wide_i[W-1:0];
    else if (wide_i[W]) narrow_o = MAX_NEG;
    else                narrow_o = MAX_POS;
  end
endmodule

// File: rtl/pe_sm_to_tc.sv
// Sign-magnitude back to W-bit two's complement, compressed with saturation.
module pe_sm_to_tc #(
  parameter int W = 5
) (
  input  logic         sign_i,
  input  logic [W-1:0] mag_i,
  output logic [W-1:0] val_o
);
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W:0] mag_ext;
  logic [W:0] wide;

  assign mag_ext = {1'b0, mag_i};
  assign wide    = sign_i ? (~mag_ext + ONE) : mag_ext;

  pe_sat_narrow #(.W(W)) u_sat (
    .wide_i   (wide),
    .narrow_o (val_o)
  );
endmodule

// File: rtl/polar_minsum_pe.sv
module polar_minsum_pe
  import polar_pe_pkg::*;
#(
  parameter int Q = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [Q-1:0] llr_a_i,
  input  logic [Q-1:0] llr_b_i,
  input  logic         u_i,
  output logic [Q-1:0] f_o,
  output logic [Q-1:0] sum_o,
  output logic [Q-1:0] diff_o,
  output logic [Q-1:0] g_o
);
  localparam int QX = Q + 1;

  // ---------------- sum / difference candidates ----------------
  logic [QX-1:0] a_ext, b_ext, s_ext, d_ext;
  logic          unused_sd_cy, unused_sd_bw;
  logic [Q-1:0]  sum_n, diff_n, g_n, f_n;

  assign a_ext = {llr_a_i[Q-1], llr_a_i};
  assign b_ext = {llr_b_i[Q-1], llr_b_i};

  pe_addsub_chain #(.W(QX)) u_sd_chain (
    .x_i      (b_ext),
    .y_i      (a_ext),
    .sum_o    (s_ext),
    .diff_o   (d_ext),
    .carry_o  (unused_sd_cy),
    .borrow_o (unused_sd_bw)
  );

  pe_sat_narrow #(.W(Q)) u_sat_sum  (.wide_i(s_ext), .narrow_o(sum_n));
  pe_sat_narrow #(.W(Q)) u_sat_diff (.wide_i(d_ext), .narrow_o(diff_n));

  g_sel_e sel;
  assign sel = g_sel_e'(u_i);
  assign g_n = (sel == SEL_DIFF) ? diff_n : sum_n;

  // ---------------- min-sum path ----------------
  logic         sgn_a, sgn_b;
  logic [Q-1:0] mag_a, mag_b, mag_min;
  logic [Q-1:0] unused_mag_sum, unused_mag_diff;
  logic         unused_mag_cy, mag_b_lt_a;

  pe_tc_to_sm #(.W(Q)) u_sm_a (.val_i(llr_a_i), .sign_o(sgn_a), .mag_o(mag_a));
  pe_tc_to_sm #(.W(Q)) u_sm_b (.val_i(llr_b_i), .sign_o(sgn_b), .mag_o(mag_b));

  // Magnitude compare: borrow out of (|b| - |a|) is set when |b| < |a|.
  pe_addsub_chain #(.W(Q)) u_mag_chain (
    .x_i      (mag_b),
    .y_i      (mag_a),
    .sum_o    (unused_mag_sum),
    .diff_o   (unused_mag_diff),
    .carry_o  (unused_mag_cy),
    .borrow_o (mag_b_lt_a)
  );

  assign mag_min = mag_b_lt_a ? mag_b : mag_a;

  pe_sm_to_tc #(.W(Q)) u_to_tc (
    .sign_i (sgn_a ^ sgn_b),
    .mag_i  (mag_min),
    .val_o  (f_n)
  );

  // ---------------- output register ----------------
  logic [Q-1:0] f_q, sum_q, diff_q, g_q;
  logic         primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q      <= '0;
      sum_q    <= '0;
      diff_q   <= '0;
      g_q      <= '0;
      primed_q <= 1'b0;
    end else begin
      f_q      <= f_n;
      sum_q    <= sum_n;
      diff_q   <= diff_n;
      g_q      <= g_n;
      primed_q <= 1'b1;
    end
  end

  assign f_o    = f_q;
  assign sum_o  = sum_q;
  assign diff_o = diff_q;
  assign g_o    = g_q;

  // ---------------- assertions ----------------
  a_r5_g_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (g_o == ($past(u_i) ? diff_o : sum_o)));

  a_r3_sum_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && ($past(llr_a_i[Q-1]) == $past(llr_b_i[Q-1])))
      |-> (sum_o[Q-1] == $past(llr_a_i[Q-1])));

  a_r4_diff_self_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && ($past(llr_a_i) == $past(llr_b_i))) |-> (diff_o == '0));

  a_r6_f_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && (f_o != '0))
      |-> (f_o[Q-1] == ($past(llr_a_i[Q-1]) ^ $past(llr_b_i[Q-1]))));

  a_r6_f_zero_input: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && (($past(llr_a_i) == '0) || ($past(llr_b_i) == '0)))
      |-> (f_o == '0));

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $stable(llr_a_i) && $stable(llr_b_i) && $stable(u_i))
      |=> $stable(f_o) && $stable(g_o));
endmodule

// File: tb/polar_minsum_pe_bench.sv
`timescale 1ns/1ps
module polar_minsum_pe_bench;
  localparam int BQ   = 5;
  localparam int VMAX = (1 << (BQ - 1)) - 1;
  localparam int VMIN = -(1 << (BQ - 1));

  logic          clk = 1'b0;
  logic          rst_n;
  logic [BQ-1:0] a, b;
  logic          u;
  logic [BQ-1:0] f_o, sum_o, diff_o, g_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  polar_minsum_pe #(.Q(BQ)) u_polar_minsum_pe (
    .clk(clk), .rst_n(rst_n), .llr_a_i(a), .llr_b_i(b), .u_i(u),
    .f_o(f_o), .sum_o(sum_o), .diff_o(diff_o), .g_o(g_o)
  );

  function automatic int clampq(int v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  function automatic int ref_f(int x, int y);
    int ax, ay, m;
    ax = (x < 0) ? -x : x;
    ay = (y < 0) ? -y : y;
    m  = (ax < ay) ? ax : ay;
    return clampq(((x < 0) != (y < 0)) ? -m : m);
  endfunction

  task automatic chk(string req, string what, logic [BQ-1:0] act, int exp);
    logic [BQ-1:0] e;
    e = BQ'(exp);
    n_checks++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what,
               $signed(act), $signed(e));
    end
  endtask

  task automatic apply(int x, int y, logic sel);
    @(negedge clk);
    a = BQ'(x); b = BQ'(y); u = sel;
    @(negedge clk);
  endtask

  task automatic check_all(int x, int y, logic sel);
    chk("R3", "sum", sum_o, clampq(y + x));
    chk("R4", "diff", diff_o, clampq(y - x));
    chk("R5", "g", g_o, sel ? clampq(y - x) : clampq(y + x));
    chk("R7", "f", f_o, ref_f(x, y));
  endtask

  // R1: outputs stay zero while reset is low, whatever the inputs.
  task automatic t_reset();
    rst_n = 1'b0; a = BQ'(7); b = BQ'(-3); u = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "f", f_o, 0);
    chk("R1", "sum", sum_o, 0);
    chk("R1", "diff", diff_o, 0);
    chk("R1", "g", g_o, 0);
    rst_n = 1'b1;
  endtask

  // R3 R4 R5 R6 R7: every operand pair with both select values.
  task automatic t_exhaustive();
    for (int x = VMIN; x <= VMAX; x++)
      for (int y = VMIN; y <= VMAX; y++)
        for (int s = 0; s < 2; s++) begin
          apply(x, y, 1'(s));
          check_all(x, y, 1'(s));
          if (x == 0 || y == 0) chk("R6", "f zero", f_o, 0);
        end
  endtask

  // R8 and clamp corners around the most negative value.
  task automatic t_corners();
    apply(VMIN, VMIN, 1'b0);
    chk("R8", "f pos sat", f_o, VMAX);
    chk("R3", "sum neg sat", sum_o, VMIN);
    chk("R4", "diff", diff_o, 0);
    apply(VMIN, 3, 1'b1);
    chk("R8", "f neg", f_o, -3);
    chk("R4", "diff pos sat", diff_o, VMAX);
    apply(1, VMIN, 1'b0);
    chk("R7", "f", f_o, -1);
    apply(VMIN, -1, 1'b0);
    chk("R8", "f", f_o, 1);
    apply(VMAX, VMAX, 1'b0);
    chk("R3", "sum pos sat", sum_o, VMAX);
    apply(VMAX, VMIN, 1'b1);
    chk("R4", "diff neg sat", diff_o, VMIN);
    chk("R8", "f", f_o, -VMAX);
  endtask

  // R9: equal magnitudes give the same f in either operand order.
  task automatic t_swap();
    logic [BQ-1:0] first;
    apply(5, -5, 1'b0);
    first = f_o;
    chk("R9", "f a,b", first, -5);
    apply(-5, 5, 1'b0);
    chk("R9", "f b,a", f_o, -5);
    apply(-6, -6, 1'b0);
    chk("R9", "f equal neg", f_o, 6);
  endtask

  // R2: a new input shows no effect until the next rising edge.
  task automatic t_latency();
    apply(2, 4, 1'b0);
    a = BQ'(-7); b = BQ'(3); u = 1'b1;
    #2;
    chk("R2", "sum held", sum_o, 6);
    chk("R2", "f held", f_o, 2);
    @(negedge clk);
    chk("R2", "g updated", g_o, 10 > VMAX ? VMAX : 10);
    chk("R2", "f updated", f_o, -3);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_swap();
    t_exhaustive();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule